// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire (I2C) serial EEPROM with a 16-bit address field. It watches the SCL and SDA lines with the system clock, finds START and STOP conditions, and takes in the device address, the read/write flag and two address bytes. It acknowledges on SDA by pulling the line low through an open-drain enable. Data bytes written by the host collect in a page buffer. They reach the internal byte array together, in one step, when the host issues STOP. After that a programming timer runs, and the device ignores its address until the timer expires.

A write-protect input blocks programming. Three read modes are supported: reading at the current address, a random read made of a dummy write followed by a repeated START, and a sequential read that runs on for as long as the host acknowledges each byte.

Top module: `eep_top`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `sda_oe` is 0, which leaves SDA released.
- R2: A byte after START is acknowledged only if its upper seven bits equal `DEV_ID`. Bit 0 is the read flag, with 1 meaning read. A byte with any other address gets no acknowledge.
- R3: A write sends the address high byte first and the low byte second, and the device acknowledges both. Only the low `ADDR_W` bits of the 16-bit field are used; the rest are ignored.
- R4: Each data byte of a write is acknowledged and advances only the low five address bits. The upper bits do not change. When more than 32 bytes arrive, the address wraps inside the same 32-byte page and overwrites earlier bytes.
- R5: The array changes only on STOP, and only if at least one data byte was accepted since the last address. A write that sends addresses but no data starts no programming cycle.
- R6: For `PROG_CYCLES` clocks after a committed write, the device address gets no acknowledge. After that it is acknowledged again.
- R7: The write-protect input is sampled at the end of the acknowledge that follows the low address byte. When it is high, the device address and both address bytes are still acknowledged, but the first data byte is not. Nothing is programmed and no busy period follows.
- R8: A read without an address phase returns the byte at the last accessed address plus one.
- R9: A dummy write of both address bytes, followed by a repeated START with the read flag set, returns the byte at that address.
- R10: While the host acknowledges each byte, reading continues at the next address. The address wraps from the top of the array to 0.
- R11: When the host does not acknowledge a read byte and then sends STOP, the device releases SDA and is ready to accept its address again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| wp_i | input | 1 | Write protect; high blocks programming |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench writes more than 32 bytes into one page, then reads the page and the byte just past it. A design that carried into the upper address bits would damage the next page, and one that failed to wrap would lose the final bytes. It polls immediately after STOP and expects a refusal, so a device that never goes busy, or that stays busy for good, is caught. It also abandons a write by issuing a repeated START before STOP and then reads the old byte back, which exposes a design that writes before STOP. It drives write protect and then reads the target byte back unchanged, and it reads across the top address into address 0. These catch a device that acknowledges protected data, and a counter that stops at the end of the array or wraps inside a page when reading.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_RNEXT
    } eep_st_e;

    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } eep_bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] id);
        return b[BYTE_W-1:1] == id;
    endfunction

endpackage

// File: rtl/eep_line_sense.sv
module eep_line_sense
    import eep_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output eep_bus_ev_t ev
);

    logic [2:0] scl_p;
    logic [2:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[1:0], scl_i};
            sda_p <= {sda_p[1:0], sda_i};
        end
    end

    always_comb begin
        ev.sda   = sda_p[1];
        ev.rise  = scl_p[1] & ~scl_p[2];
        ev.fall  = ~scl_p[1] & scl_p[2];
        ev.start = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
        ev.stop  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
    end

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int PROG_CYCLES = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [7:0]               buf_data,
    input  logic                     buf_clr,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     busy
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

    logic [7:0]        mem  [DEPTH];
    logic [7:0]        pbuf [PAGE_N];
    logic [PAGE_N-1:0] valid;
    logic [CNT_W-1:0]  cnt;
    logic              launch;

    assign busy    = (cnt != '0);
    assign launch  = commit && !busy;
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
        if (launch) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (valid[i]) mem[{page, PAGE_W'(i)}] <= pbuf[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            cnt   <= '0;
        end else if (launch) begin
            valid <= '0;
            cnt   <= CNT_W'(PROG_CYCLES);
        end else begin
            if (busy) cnt <= cnt - 1'b1;
            if (buf_clr)     valid          <= '0;
            else if (buf_we) valid[buf_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'h50,
    parameter int         ADDR_W = 12,
    parameter int         PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  eep_bus_ev_t       ev,
    input  logic              wp_i,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] ptr,
    output logic              buf_we,
    output logic [PAGE_W-1:0] buf_idx,
    output logic [7:0]        buf_data,
    output logic              buf_clr,
    output logic              commit,
    output eep_st_e           st
);

    eep_st_e    ret_st;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic       wp_lat;
    logic       samp_wp;
    logic       have_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ret_st    <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txsh      <= '0;
            sda_oe    <= 1'b0;
            ptr       <= '0;
            wp_lat    <= 1'b0;
            samp_wp   <= 1'b0;
            have_data <= 1'b0;
            buf_we    <= 1'b0;
            buf_idx   <= '0;
            buf_data  <= '0;
            buf_clr   <= 1'b0;
            commit    <= 1'b0;
        end else begin
            buf_we  <= 1'b0;
            buf_clr <= 1'b0;
            commit  <= 1'b0;
            if (ev.start) begin
                st      <= ST_DEV;
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
                samp_wp <= 1'b0;
            end else if (ev.stop) begin
                st        <= ST_IDLE;
                sda_oe    <= 1'b0;
                commit    <= have_data;
                have_data <= 1'b0;
            end else begin
                case (st)
                    ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
                        if (ev.rise) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            case (st)
                                ST_DEV: begin
                                    if (addr_hit(shreg, DEV_ID) && !busy) begin
                                        sda_oe <= 1'b1;
                                        st     <= ST_ACK;
                                        ret_st <= shreg[0] ? ST_TX : ST_AHI;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                ST_AHI: begin
                                    ptr[ADDR_W-1:8] <= shreg[ADDR_W-9:0];
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                    ret_st <= ST_ALO;
                                end
                                ST_ALO: begin
                                    ptr[7:0]  <= shreg;
                                    buf_clr   <= 1'b1;
                                    have_data <= 1'b0;
                                    samp_wp   <= 1'b1;
                                    sda_oe    <= 1'b1;
                                    st        <= ST_ACK;
                                    ret_st    <= ST_WR;
                                end
                                default: begin
                                    if (wp_lat) begin
                                        st <= ST_IDLE;
                                    end else begin
                                        buf_we    <= 1'b1;
                                        buf_idx   <= ptr[PAGE_W-1:0];
                                        buf_data  <= shreg;
                                        ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                                        have_data <= 1'b1;
                                        sda_oe    <= 1'b1;
                                        st        <= ST_ACK;
                                        ret_st    <= ST_WR;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            if (samp_wp) begin
                                wp_lat  <= wp_i;
                                samp_wp <= 1'b0;
                            end
                            if (ret_st == ST_TX) begin
                                txsh   <= rd_data;
                                sda_oe <= !rd_data[7];
                                ptr    <= ptr + 1'b1;
                                st     <= ST_TX;
                            end else begin
                                st <= ret_st;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ST_RACK;
                            end else begin
                                txsh   <= {txsh[6:0], 1'b0};
                                sda_oe <= !txsh[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) st <= ev.sda ? ST_IDLE : ST_RNEXT;
                    end
                    ST_RNEXT: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            txsh   <= rd_data;
                            sda_oe <= !rd_data[7];
                            ptr    <= ptr + 1'b1;
                            st     <= ST_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/eep_top.sv
module eep_top
    import eep_pkg::*;
#(
    parameter logic [6:0] DEV_ID      = 7'h50,
    parameter int         ADDR_W      = 12,
    parameter int         PAGE_W      = 5,
    parameter int         PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);

    eep_bus_ev_t       ev;
    eep_st_e           st;
    logic [ADDR_W-1:0] ptr;
    logic              buf_we;
    logic [PAGE_W-1:0] buf_idx;
    logic [7:0]        buf_data;
    logic              buf_clr;
    logic              commit;
    logic              busy;
    logic [7:0]        rd_data;

    eep_line_sense u_sense (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_ctrl #(
        .DEV_ID (DEV_ID),
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .wp_i     (wp_i),
        .busy     (busy),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .ptr      (ptr),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .buf_data (buf_data),
        .buf_clr  (buf_clr),
        .commit   (commit),
        .st       (st)
    );

    eep_store #(
        .ADDR_W      (ADDR_W),
        .PAGE_W      (PAGE_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .buf_data (buf_data),
        .buf_clr  (buf_clr),
        .commit   (commit),
        .page     (ptr[ADDR_W-1:PAGE_W]),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .busy     (busy)
    );

endmodule

// File: rtl/eep_chk.sv
module eep_chk
    import eep_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              busy,
    input logic              commit,
    input logic              buf_we,
    input logic [ADDR_W-1:0] ptr,
    input eep_st_e           st
);

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> !sda_oe);

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    // R6
    poll_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(st) == ST_DEV) |-> st != ST_ACK);

endmodule

bind eep_top eep_chk #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sda_oe (sda_oe),
    .busy   (busy),
    .commit (commit),
    .buf_we (buf_we),
    .ptr    (ptr),
    .st     (st)
);

// File: tb/test_eep_top.sv
module test_eep_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] DEV = 7'h50;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eep_top #(
        .DEV_ID      (DEV),
        .ADDR_W      (12),
        .PAGE_W      (5),
        .PROG_CYCLES (PROG)
    ) i_eep_top (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0]  mem_m [4096];
    bit          known [4096];
    logic [11:0] ptr_m = '0;
    logic [7:0]  wbuf [64];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(4);
        sda_m = 1'b0; tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(4);
        sda_m = 1'b1; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(4);
            scl_m = 1'b1; tick(8);
            scl_m = 1'b0; tick(4);
        end
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(4);
        ack = !sda_bus; tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(4);
            scl_m = 1'b1; tick(4);
            b = {b[6:0], sda_bus}; tick(4);
            scl_m = 1'b0; tick(4);
        end
        sda_m = !mack; tick(4);
        scl_m = 1'b1; tick(8);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic fill_wbuf(input int n);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input bit wp_on);
        logic ack;
        wp = wp_on;
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R2 device address ack on write", ack, 1);
        send_byte(a[15:8], ack);
        chk(ack, "R3 high address byte ack", ack, 1);
        send_byte(a[7:0], ack);
        chk(ack, "R3 low address byte ack", ack, 1);
        ptr_m = a[11:0];
        if (wp_on) begin
            send_byte(wbuf[0], ack);
            chk(!ack, "R7 protected data byte nack", ack, 0);
        end else begin
            for (int i = 0; i < n; i++) begin
                send_byte(wbuf[i], ack);
                chk(ack, "R4 data byte ack", ack, 1);
                mem_m[ptr_m] = wbuf[i];
                known[ptr_m] = 1'b1;
                ptr_m = {ptr_m[11:5], ptr_m[4:0] + 5'd1};
            end
        end
        i2c_stop();
        wp = 1'b0;
    endtask

    task automatic poll(output int polls);
        logic ack;
        ack = 1'b0;
        polls = 0;
        while (!ack && polls < 30) begin
            i2c_start();
            send_byte({DEV, 1'b0}, ack);
            i2c_stop();
            polls++;
        end
        chk(ack, "R6 device answers again after programming", ack, 1);
    endtask

    task automatic read_bytes(input int n, input string tag);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            if (known[ptr_m]) chk(b == mem_m[ptr_m], tag, b, mem_m[ptr_m]);
            ptr_m = ptr_m + 12'd1;
        end
    endtask

    task automatic rand_read(input logic [15:0] a, input int n, input string tag);
        logic ack;
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R9 dummy write device ack", ack, 1);
        send_byte(a[15:8], ack);
        send_byte(a[7:0], ack);
        chk(ack, "R9 dummy write address ack", ack, 1);
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        chk(ack, "R9 read device ack after repeated start", ack, 1);
        ptr_m = a[11:0];
        read_bytes(n, tag);
        i2c_stop();
        tick(4);
        chk(sda_oe == 1'b0, "R11 line released after nack and stop", sda_oe, 0);
    endtask

    task automatic cur_read(input int n, input string tag);
        logic ack;
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        chk(ack, "R8 device ack for current read", ack, 1);
        read_bytes(n, tag);
        i2c_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        int   polls;
        void'($urandom(32'd1789));
        for (int i = 0; i < 4096; i++) known[i] = 1'b0;
        tick(5);
        rst = 1'b0;
        tick(5);
        chk(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);

        // R2: foreign address is ignored
        i2c_start();
        send_byte({7'h51, 1'b0}, ack);
        chk(!ack, "R2 foreign address nack", ack, 0);
        i2c_stop();
        tick(4);
        chk(sda_oe == 1'b0, "R1 line released when idle", sda_oe, 0);

        // R3: upper address bits ignored; R6 busy polling
        wbuf[0] = 8'h5A;
        do_write(16'hF345, 1, 1'b0);
        poll(polls);
        chk(polls > 1, "R6 first poll after commit nacked", polls, 2);
        rand_read(16'h0345, 1, "R3 byte lands at low address bits");

        // R4: page overflow wraps and leaves the next page alone
        wbuf[0] = 8'hEE;
        wbuf[1] = 8'h3C;
        do_write(16'h0140, 2, 1'b0);
        poll(polls);
        fill_wbuf(40);
        do_write(16'h0125, 40, 1'b0);
        poll(polls);
        rand_read(16'h0120, 32, "R4 page content after wrap");
        rand_read(16'h013E, 3, "R4 neighbouring page untouched");
        // R8: current address continues at 0x141
        cur_read(1, "R8 current address read");
        chk(ptr_m == 12'h142, "R8 model address advanced", ptr_m, 12'h142);

        // R7: protected write
        wbuf[0] = 8'h11;
        do_write(16'h0345, 1, 1'b1);
        poll(polls);
        chk(polls == 1, "R7 no busy period after protected write", polls, 1);
        rand_read(16'h0345, 1, "R7 protected byte unchanged");

        // R5: data abandoned by repeated start is never written
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h03, ack);
        send_byte(8'h45, ack);
        send_byte(8'h77, ack);
        chk(ack, "R5 staged byte accepted", ack, 1);
        i2c_start();
        send_byte({DEV, 1'b0}, ack);
        chk(ack, "R5 no programming before stop", ack, 1);
        send_byte(8'h03, ack);
        send_byte(8'h45, ack);
        i2c_start();
        send_byte({DEV, 1'b1}, ack);
        ptr_m = 12'h345;
        read_bytes(1, "R5 array unchanged before stop");
        i2c_stop();
        poll(polls);
        chk(polls == 1, "R5 address-only write starts no cycle", polls, 1);

        // R10: sequential read wraps from top to zero
        fill_wbuf(32);
        do_write(16'h0FE0, 32, 1'b0);
        poll(polls);
        wbuf[0] = 8'hA5;
        wbuf[1] = 8'h0F;
        do_write(16'h0000, 2, 1'b0);
        poll(polls);
        rand_read(16'h0FFE, 4, "R10 sequential read across top");

        // constrained random traffic
        for (int it = 0; it < 10; it++) begin
            logic [15:0] a;
            int n;
            a = 16'($urandom);
            n = 1 + int'($urandom % 10);
            fill_wbuf(n);
            do_write(a, n, 1'b0);
            poll(polls);
            chk(polls > 1, "R6 random write busy", polls, 2);
            rand_read({4'h0, a[11:5], 5'd0}, 32, "R4 random page readback");
            cur_read(2, "R8 random current read");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule